// File: doc/BRIEF.md
# Four-Channel Converter Code Bank with Deferred Load

This block sits behind a serial receiver and turns each 16-bit command word into an update of one of four converter channels. A word names its target channel, carries a settling-speed selection, a per-channel software sleep bit and a 12-bit code. The code first lands in the channel's staging register. It moves on to the channel's output register only while the active-low load input is asserted. Software can therefore stage new codes on several channels while load is held high and then release them all in the same clock by pulling load low.

The speed and sleep settings take effect as soon as the word is taken and do not wait for load. An active-low hardware power-down input overrides every channel's own sleep bit and drives all power enables low at once. It leaves the stored sleep bits unchanged. An asynchronous active-low reset models the power-on reset and puts every register into a known state.

Top module: `quad_dac_bank`

## Requirements
- R1: While and after reset, every output code is 0, every fastMode bit is 0 (slow), and every stored sleep bit is clear, so powerEn is all ones while pwrDownN is high.
- R2: A word taken with wordValid high is decoded as follows: bits [15:14] give the channel (00 is channel 0, 01 is channel 1, 10 is channel 2, 11 is channel 3, where channel i owns codeOut[12*i+11:12*i]), bit 13 is the fast select, bit 12 is the sleep bit (1 means asleep) and bits [11:0] are the code.
- R3: The fast select of a taken word appears on fastMode of the addressed channel after the next clock edge, whatever the value of loadN.
- R4: While loadN is high at a clock edge, no output code changes at that edge.
- R5: While loadN is low at a clock edge, every output code takes its channel's staged code at that edge, so codes staged under loadN high are released together.
- R6: When a word and loadN low occur in the same cycle, the new code is on the addressed channel's output after that cycle's clock edge.
- R7: The sleep bit of a taken word is stored for the addressed channel after the next edge, whatever the value of loadN, and powerEn of that channel equals pwrDownN AND NOT the stored bit.
- R8: While pwrDownN is low, powerEn is all zeros in the same cycle, and the stored sleep bits are kept, so the earlier per-channel enables return when pwrDownN goes high.
- R9: A word changes only the staging register, fast bit and sleep bit of its addressed channel. The other channels keep theirs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wordValid | input | 1 | A command word is present this cycle |
| wordData | input | 16 | Command word: channel, fast, sleep, code |
| loadN | input | 1 | Active-low load; low lets staged codes reach the outputs |
| pwrDownN | input | 1 | Active-low hardware power-down of all channels |
| codeOut | output | 48 | Four 12-bit output codes, channel i at bits 12*i+11:12*i |
| powerEn | output | 4 | Per-channel power enable |
| fastMode | output | 4 | Per-channel fast settling select |

## Verification
Random words go to random channels while loadN and pwrDownN toggle at random. This tells apart designs that confuse the channel field, mix up the fast and sleep bits, or let a word disturb a neighbour channel. A directed sequence stages distinct codes on all four channels with loadN high, checks that no output has moved, and then releases them with a single low cycle. That separates true double buffering from a pass-through register. Further directed cases send a word in the same cycle as loadN low, to show the staging register is bypassed, and hold pwrDownN low across sleep-bit writes, to show the hardware override masks the stored bits without erasing them.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int NUM_CH   = 4;
  localparam int CODE_W   = 12;
  localparam int ADDR_W   = $clog2(NUM_CH);
  localparam int WORD_W   = ADDR_W + 2 + CODE_W;
  localparam int SLEEP_B  = CODE_W;
  localparam int FAST_B   = CODE_W + 1;
  localparam int ADDR_LSB = CODE_W + 2;

  typedef struct packed {
    logic [NUM_CH-1:0] chWrite;
    logic [CODE_W-1:0] code;
    logic              fastSel;
    logic              sleepSel;
    logic              loadAll;
  } bankStrobes_t;
endpackage

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
(
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              loadN,
  output bankStrobes_t      strobes
);
  logic [ADDR_W-1:0] chSel;

  assign chSel = wordData[ADDR_LSB +: ADDR_W];

  always_comb begin
    strobes          = '0;
    strobes.code     = wordData[CODE_W-1:0];
    strobes.fastSel  = wordData[FAST_B];
    strobes.sleepSel = wordData[SLEEP_B];
    strobes.loadAll  = ~loadN;
    for (int i = 0; i < NUM_CH; i++) begin
      strobes.chWrite[i] = wordValid && (chSel == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/dacbank_datapath.sv
module dacbank_datapath
  import dacbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  bankStrobes_t             strobes,
  input  logic                     pwrDownN,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        powerEn,
  output logic [NUM_CH-1:0]        fastMode
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] stageCode;
    logic [CODE_W-1:0] liveCode;
    logic              fastReg;
    logic              sleepReg;
    logic [CODE_W-1:0] nextStage;

    assign nextStage = strobes.chWrite[ch] ? strobes.code : stageCode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageCode <= '0;
        fastReg   <= 1'b0;
        sleepReg  <= 1'b0;
      end else if (strobes.chWrite[ch]) begin
        stageCode <= strobes.code;
        fastReg   <= strobes.fastSel;
        sleepReg  <= strobes.sleepSel;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveCode <= '0;
      end else if (strobes.loadAll) begin
        liveCode <= nextStage;
      end
    end

    assign codeOut[ch*CODE_W +: CODE_W] = liveCode;
    assign fastMode[ch] = fastReg;
    assign powerEn[ch]  = pwrDownN & ~sleepReg;
  end
endmodule

// File: rtl/quad_dac_bank.sv
module quad_dac_bank
  import dacbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wordValid,
  input  logic [WORD_W-1:0]        wordData,
  input  logic                     loadN,
  input  logic                     pwrDownN,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH-1:0]        powerEn,
  output logic [NUM_CH-1:0]        fastMode
);
  bankStrobes_t strobes;

  dacbank_ctrl u_ctrl (
    .wordValid (wordValid),
    .wordData  (wordData),
    .loadN     (loadN),
    .strobes   (strobes)
  );

  dacbank_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pwrDownN (pwrDownN),
    .codeOut  (codeOut),
    .powerEn  (powerEn),
    .fastMode (fastMode)
  );
endmodule

// File: rtl/dacbank_checker.sv
module dacbank_checker
  import dacbank_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     wordValid,
  input logic [WORD_W-1:0]        wordData,
  input logic                     loadN,
  input logic                     pwrDownN,
  input logic [NUM_CH*CODE_W-1:0] codeOut,
  input logic [NUM_CH-1:0]        powerEn,
  input logic [NUM_CH-1:0]        fastMode
);
  function automatic logic [CODE_W-1:0] chanCode(
      input logic [NUM_CH*CODE_W-1:0] v, input logic [ADDR_W-1:0] idx);
    return v[idx*CODE_W +: CODE_W];
  endfunction

  function automatic logic [ADDR_W-1:0] addrOf(input logic [WORD_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction

  assert_hold_while_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> $stable(codeOut));

  assert_same_cycle_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !loadN) |=>
      chanCode(codeOut, addrOf($past(wordData))) == $past(wordData[CODE_W-1:0]));

  assert_fast_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> fastMode[addrOf($past(wordData))] == $past(wordData[FAST_B]));

  assert_sleep_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> powerEn[addrOf($past(wordData))] == (pwrDownN & ~$past(wordData[SLEEP_B])));

  assert_hw_override_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |-> powerEn == '0);
endmodule

bind quad_dac_bank dacbank_checker u_chk (.*);

// File: tb/quad_dac_bank_tb.sv
module quad_dac_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        loadN = 1'b1;
  logic        pwrDownN = 1'b1;
  logic [47:0] codeOut;
  logic [3:0]  powerEn;
  logic [3:0]  fastMode;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;
  bit done = 1'b0;

  logic [11:0] mStage [4];
  logic [11:0] mLive  [4];
  logic        mFast  [4];
  logic        mSleep [4];

  quad_dac_bank u_dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .loadN(loadN), .pwrDownN(pwrDownN), .codeOut(codeOut),
    .powerEn(powerEn), .fastMode(fastMode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [47:0] expCodes();
    logic [47:0] v;
    for (int i = 0; i < 4; i++) v[i*12 +: 12] = mLive[i];
    return v;
  endfunction

  function automatic logic [3:0] expFast();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = mFast[i];
    return v;
  endfunction

  function automatic logic [3:0] expPower(input logic hw);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = hw & ~mSleep[i];
    return v;
  endfunction

  function automatic logic [15:0] mkWord(input int ch, input bit f, input bit s,
                                         input logic [11:0] c);
    return {ch[1:0], f, s, c};
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mStage[i] = '0; mLive[i] = '0; mFast[i] = 1'b0; mSleep[i] = 1'b0;
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check at the next falling edge.
  task automatic step(input bit v, input logic [15:0] w, input bit ld, input bit hw);
    int ch;
    wordValid = v; wordData = w; loadN = ld; pwrDownN = hw;
    if (v) begin
      ch = int'(w[15:14]);
      mStage[ch] = w[11:0];
      mFast[ch]  = w[13];
      mSleep[ch] = w[12];
    end
    if (!ld) for (int i = 0; i < 4; i++) mLive[i] = mStage[i];
    @(posedge clk);
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " codes"}, codeOut, expCodes());
    chk({tag, " fast"}, {44'd0, fastMode}, {44'd0, expFast()});
    chk({tag, " power"}, {44'd0, powerEn}, {44'd0, expPower(pwrDownN)});
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > MAX_CYCLES && !done) begin
        done = 1'b1;
        failCount++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycleCount, MAX_CYCLES);
        $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] savedPower;
    void'($urandom(32'h5EED1234));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is held and right after release
    checkAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R4: stage distinct codes on all channels with load held high
    step(1'b1, mkWord(0, 1'b0, 1'b0, 12'h111), 1'b1, 1'b1);
    step(1'b1, mkWord(1, 1'b1, 1'b0, 12'h222), 1'b1, 1'b1);
    step(1'b1, mkWord(2, 1'b0, 1'b0, 12'h333), 1'b1, 1'b1);
    step(1'b1, mkWord(3, 1'b1, 1'b0, 12'hFFF), 1'b1, 1'b1);
    chk("R4 codes held", codeOut, 48'd0);
    // R3: fast bits took effect with load high
    chk("R3 fast without load", {44'd0, fastMode}, 48'b1010);
    // R5: one low cycle releases all four together
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    chk("R5 simultaneous release", codeOut, {12'hFFF, 12'h333, 12'h222, 12'h111});
    // R6: word with load low appears after the same edge
    step(1'b1, mkWord(2, 1'b0, 1'b0, 12'hABC), 1'b0, 1'b1);
    chk("R6 same-cycle load", codeOut, {12'hFFF, 12'hABC, 12'h222, 12'h111});
    // R9: word to channel 1 leaves others alone
    step(1'b1, mkWord(1, 1'b0, 1'b0, 12'h5A5), 1'b1, 1'b1);
    step(1'b0, 16'h0000, 1'b0, 1'b1);
    chk("R9 neighbours kept", codeOut, {12'hFFF, 12'hABC, 12'h5A5, 12'h111});
    // R7: sleep bit on channel 3 with load high
    step(1'b1, mkWord(3, 1'b1, 1'b1, 12'h000), 1'b1, 1'b1);
    chk("R7 sleep bit", {44'd0, powerEn}, 48'b0111);
    // R2: field positions; bit 13 only to channel 0
    step(1'b1, 16'b00_1_0_0000_0000_0001, 1'b0, 1'b1);
    chk("R2 decode fields", {36'd0, codeOut[11:0]}, 48'h001);
    chk("R2 fast bit 13", {47'd0, fastMode[0]}, 48'd1);
    // R8: hardware power-down masks all, keeps stored bits
    savedPower = powerEn;
    step(1'b0, 16'h0000, 1'b1, 1'b0);
    chk("R8 override low", {44'd0, powerEn}, 48'd0);
    step(1'b1, mkWord(1, 1'b0, 1'b1, 12'h010), 1'b1, 1'b0);
    chk("R8 override during write", {44'd0, powerEn}, 48'd0);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    chk("R8 release restores", {44'd0, powerEn}, {44'd0, savedPower & 4'b1101});

    // R2 R4 R5 R9: random mix against the model
    for (int n = 0; n < 400; n++) begin
      bit v, ld, hw;
      logic [15:0] w;
      v  = ($urandom % 4) != 0;
      w  = 16'($urandom);
      ld = ($urandom % 3) != 0;
      hw = ($urandom % 6) != 0;
      step(v, w, ld, hw);
      checkAll("R2 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule